// File: doc/BRIEF.md
# Byte-View Register File

This block is the integer register file of a small core. It holds eight 32-bit registers and four 1-bit condition flags. Each of its two read ports and its single write port carries a size select, so a port reaches either a whole word register or an 8-bit view. The 8-bit views overlay the two low bytes of the first four word registers.

Byte index `k` in the range 0 to 3 names bits 7:0 of word register `k`. Byte index `k` in the range 4 to 7 names bits 15:8 of word register `k-4`. Word registers 4 to 7 have no byte view at all.

Reads are combinational, and a write in flight is visible on the read ports in the same cycle. The flags are loaded through a port of their own, and register writes do not touch them.

Top module: `byte_view_regfile`

## Requirements
- R1: While `rst_n` is low, all eight word registers and all four flags are cleared to zero.
- R2: A word write (`wr_en`=1, `wr_byte`=0) stores all 32 bits of `wr_data` into register `wr_idx` at the clock edge.
- R3: A byte access with index 0..3 maps to bits 7:0 of register 0..3, and index 4..7 maps to bits 15:8 of register 0..3. With register 3 holding 0x11223344, byte index 3 reads 0x44 and byte index 7 reads 0x33.
- R4: A byte read returns the selected byte zero-extended to 32 bits, so bits 31:8 of the read port are 0.
- R5: A byte write replaces only the selected byte with `wr_data[7:0]`. The other 24 bits of that word register keep their values.
- R6: Word registers 4 to 7 are never altered by a byte write, whatever the byte index.
- R7: When the write port and a read port address the same storage in one cycle, the read port already shows the value being written, merged into the word for a byte write.
- R8: The two read ports are independent and can read different registers and sizes in the same cycle.
- R9: When `flag_we`=1, `flag_in` is loaded into the flags at the clock edge. Bit positions are [3]=sign, [2]=zero, [1]=carry, [0]=overflow on both `flag_in` and `flags`.
- R10: The flags hold their value when `flag_we`=0, including across register writes.
- R11: When `wr_en`=0, no register changes, whatever `wr_idx`, `wr_byte` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 3 | Read port A index (word or byte index) |
| rd_a_byte | input | 1 | Read port A size: 1 = byte view, 0 = word |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 3 | Read port B index |
| rd_b_byte | input | 1 | Read port B size |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write index (word or byte index) |
| wr_byte | input | 1 | Write size: 1 = byte view, 0 = word |
| wr_data | input | 32 | Write data; only bits 7:0 are used for a byte write |
| flag_we | input | 1 | Flag load enable |
| flag_in | input | 4 | New flags {sign, zero, carry, overflow} |
| flags | output | 4 | Current flags {sign, zero, carry, overflow} |

## Verification
The bench builds the block with its default parameters: 32-bit words, eight registers, four of which carry byte views. This makes all sixteen word and byte indices reachable, including the four registers with no byte view. Byte writes aimed at every byte index can therefore be shown to leave registers 4 to 7 untouched, while the high and low lanes of registers 0 to 3 are merged and read back through both ports. Same-cycle forwarding is observed on the read ports before the edge that commits the write.

// File: rtl/byte_view_regfile.sv
module byte_view_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int NBV    = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  input  logic                    rd_a_byte,
  output logic [DATA_W-1:0]       rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  input  logic                    rd_b_byte,
  output logic [DATA_W-1:0]       rd_b_data,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic                    wr_byte,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    flag_we,
  input  logic [3:0]              flag_in,
  output logic [3:0]              flags
);
  localparam int IW = $clog2(NREG);
  localparam int BW = $clog2(NBV);
  localparam int PAD = DATA_W - BYTE_W;

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] nxt  [NREG];
  logic [3:0]        flags_q;

  function automatic logic [IW-1:0] byte_owner(input logic [IW-1:0] idx);
    return IW'(idx[BW-1:0]);
  endfunction

  logic [IW-1:0] wr_tgt;
  assign wr_tgt = wr_byte ? byte_owner(wr_idx) : wr_idx;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      nxt[i] = regs[i];
      if (wr_en && wr_tgt == IW'(i)) begin
        if (!wr_byte)
          nxt[i] = wr_data;
        else if (wr_idx[BW])
          nxt[i][2*BYTE_W-1:BYTE_W] = wr_data[BYTE_W-1:0];
        else
          nxt[i][BYTE_W-1:0] = wr_data[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      flags_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
      if (flag_we) flags_q <= flag_in;
    end
  end

  logic [IW-1:0]     a_reg, b_reg;
  logic [DATA_W-1:0] a_word, b_word;
  logic [BYTE_W-1:0] a_sel, b_sel;

  assign a_reg  = rd_a_byte ? byte_owner(rd_a_idx) : rd_a_idx;
  assign b_reg  = rd_b_byte ? byte_owner(rd_b_idx) : rd_b_idx;
  assign a_word = nxt[a_reg];
  assign b_word = nxt[b_reg];
  assign a_sel  = rd_a_idx[BW] ? a_word[2*BYTE_W-1:BYTE_W] : a_word[BYTE_W-1:0];
  assign b_sel  = rd_b_idx[BW] ? b_word[2*BYTE_W-1:BYTE_W] : b_word[BYTE_W-1:0];

  assign rd_a_data = rd_a_byte ? {{PAD{1'b0}}, a_sel} : a_word;
  assign rd_b_data = rd_b_byte ? {{PAD{1'b0}}, b_sel} : b_word;
  assign flags     = flags_q;
endmodule

// File: rtl/byte_view_regfile_chk.sv
module byte_view_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int NBV    = 4,
  parameter int BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [$clog2(NREG)-1:0] rd_a_idx,
  input logic                    rd_a_byte,
  input logic [DATA_W-1:0]       rd_a_data,
  input logic [$clog2(NREG)-1:0] rd_b_idx,
  input logic                    rd_b_byte,
  input logic [DATA_W-1:0]       rd_b_data,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic                    wr_byte,
  input logic [DATA_W-1:0]       wr_data,
  input logic                    flag_we,
  input logic [3:0]              flag_in,
  input logic [3:0]              flags
);
  a_r1_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> flags == 4'b0);

  a_r4_zext_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_byte |-> rd_a_data[DATA_W-1:BYTE_W] == '0);

  a_r4_zext_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_byte |-> rd_b_data[DATA_W-1:BYTE_W] == '0);

  a_r7_fwd_word_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && !rd_a_byte && rd_a_idx == wr_idx) |-> rd_a_data == wr_data);

  a_r7_fwd_word_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && !rd_b_byte && rd_b_idx == wr_idx) |-> rd_b_data == wr_data);

  a_r7_fwd_byte_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && rd_a_byte && rd_a_idx == wr_idx)
      |-> rd_a_data[BYTE_W-1:0] == wr_data[BYTE_W-1:0]);

  a_r9_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> flags == $past(flag_in));

  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en) && $stable(rd_a_idx) && $stable(rd_a_byte))
      |-> $stable(rd_a_data));
endmodule

bind byte_view_regfile byte_view_regfile_chk #(
  .DATA_W(DATA_W), .NREG(NREG), .NBV(NBV), .BYTE_W(BYTE_W)
) i_chk (.*);

// File: tb/test_byte_view_regfile.sv
`timescale 1ns/1ps
module test_byte_view_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic        rd_a_byte = 0, rd_b_byte = 0, wr_en = 0, wr_byte = 0, flag_we = 0;
  logic [31:0] wr_data = 0;
  logic [3:0]  flag_in = 0;
  logic [31:0] rd_a_data, rd_b_data;
  logic [3:0]  flags;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m [8];

  always #10 clk = ~clk;

  byte_view_regfile i_byte_view_regfile (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_byte(input int idx);
    return idx < 4 ? {24'h0, m[idx][7:0]} : {24'h0, m[idx-4][15:8]};
  endfunction

  task automatic wr(input int idx, input bit b, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx[2:0]; wr_byte = b; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (!b) m[idx] = d;
    else if (idx < 4) m[idx][7:0] = d[7:0];
    else m[idx-4][15:8] = d[7:0];
  endtask

  task automatic rd_a(input int idx, input bit b, output logic [31:0] v);
    rd_a_idx = idx[2:0]; rd_a_byte = b; #1; v = rd_a_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd_a(i, 0, v); chk("R1 word reg cleared", v, 0);
    end
    chk("R1 flags cleared", {28'h0, flags}, 0);
  endtask

  task automatic t_word;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr(i, 0, 32'hA5000000 + 32'(i) * 32'h01010101);
    for (int i = 0; i < 8; i++) begin
      rd_a(i, 0, v); chk("R2 word write stored", v, m[i]);
    end
    rd_a_idx = 1; rd_a_byte = 0; rd_b_idx = 6; rd_b_byte = 1; #1;
    chk("R8 port A word", rd_a_data, m[1]);
    chk("R8 port B byte", rd_b_data, exp_byte(6));
    rd_b_idx = 5; rd_b_byte = 0; #1;
    chk("R8 port B word", rd_b_data, m[5]);
  endtask

  task automatic t_byte_map;
    logic [31:0] v;
    wr(3, 0, 32'h11223344);
    rd_a(3, 1, v); chk("R3 byte idx 3 low lane", v, 32'h44);
    rd_a(7, 1, v); chk("R3 byte idx 7 high lane", v, 32'h33);
    wr(0, 0, 32'hFFFF_FF80);
    rd_a(0, 1, v); chk("R4 zero-extend low", v, 32'h80);
    rd_a(4, 1, v); chk("R4 zero-extend high", v, 32'hFF);
    for (int i = 0; i < 8; i++) begin
      rd_a(i, 1, v); chk("R3 byte map", v, exp_byte(i));
    end
  endtask

  task automatic t_byte_merge;
    logic [31:0] v;
    wr(2, 0, 32'hDEADBEEF);
    wr(2, 1, 32'hFFFFFF12);
    rd_a(2, 0, v); chk("R5 low byte merge", v, 32'hDEADBE12);
    wr(6, 1, 32'h00000077);
    rd_a(2, 0, v); chk("R5 high byte merge", v, 32'hDEAD7712);
    wr(1, 0, 32'h01234567);
    wr(5, 1, 32'hAB);
    wr(1, 1, 32'hCD);
    rd_a(1, 0, v); chk("R5 both lanes merged", v, 32'h0123ABCD);
  endtask

  task automatic t_no_view;
    logic [31:0] v;
    for (int i = 4; i < 8; i++) wr(i, 0, 32'h5A5A0000 | 32'(i));
    for (int i = 0; i < 8; i++) wr(i, 1, 32'hC0 + 32'(i));
    for (int i = 4; i < 8; i++) begin
      rd_a(i, 0, v); chk("R6 no byte view reg unchanged", v, 32'h5A5A0000 | 32'(i));
    end
  endtask

  task automatic t_forward;
    @(negedge clk);
    wr_en = 1; wr_idx = 4; wr_byte = 0; wr_data = 32'hCAFEF00D;
    rd_a_idx = 4; rd_a_byte = 0; rd_b_idx = 4; rd_b_byte = 0; #2;
    chk("R7 fwd word port A", rd_a_data, 32'hCAFEF00D);
    chk("R7 fwd word port B", rd_b_data, 32'hCAFEF00D);
    @(posedge clk); #1; wr_en = 0; m[4] = 32'hCAFEF00D;
    @(negedge clk);
    wr_en = 1; wr_idx = 7; wr_byte = 1; wr_data = 32'h9E;
    rd_a_idx = 3; rd_a_byte = 0; rd_b_idx = 7; rd_b_byte = 1; #2;
    chk("R7 fwd byte merged word", rd_a_data, {m[3][31:16], 8'h9E, m[3][7:0]});
    chk("R7 fwd byte view", rd_b_data, 32'h9E);
    @(posedge clk); #1; wr_en = 0; m[3][15:8] = 8'h9E;
  endtask

  task automatic t_flags;
    @(negedge clk); flag_we = 1; flag_in = 4'b1010;
    @(posedge clk); #1; flag_we = 0;
    chk("R9 flags loaded SF,CF", {28'h0, flags}, 32'hA);
    @(negedge clk); flag_we = 1; flag_in = 4'b0101;
    @(posedge clk); #1; flag_we = 0;
    chk("R9 flags loaded ZF,OF", {28'h0, flags}, 32'h5);
    flag_in = 4'b1111;
    wr(0, 0, 32'h0);
    wr(2, 1, 32'hFF);
    chk("R10 flags held over writes", {28'h0, flags}, 32'h5);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    @(negedge clk);
    wr_en = 0; wr_idx = 5; wr_byte = 0; wr_data = 32'h13579BDF;
    @(posedge clk); #1;
    wr_idx = 1; wr_byte = 1; wr_data = 32'h66;
    @(posedge clk); #1;
    rd_a(5, 0, v); chk("R11 idle word unchanged", v, m[5]);
    rd_a(1, 0, v); chk("R11 idle byte unchanged", v, m[1]);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    #1; t_reset;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_word;
    t_byte_map;
    t_byte_merge;
    t_no_view;
    t_forward;
    t_flags;
    t_idle;
    repeat (2) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule